// File: doc/BRIEF.md
# Parallel Write Strobe Qualifier

This block sits behind the control pins of an asynchronous parallel memory bus and runs on a fast system clock. It samples the active-low chip enable, write enable and output enable pins, the supply-good flag, the address bus and the data bus through a short synchroniser chain. From those samples it decides when a real write strobe has happened. A write strobe is the time during which chip enable and write enable are both low, output enable is high and the supply is good.

The address is taken at the moment the strobe opens, which is when the later of the two enable falling edges arrives. The data is taken at the moment it closes, which is when the earlier of the two rising edges arrives. A strobe that held for fewer than a minimum number of clocks is dropped as a glitch. The minimum is derived from a clock-period parameter and a minimum-pulse-width parameter. A strobe that ends because output enable went low or because the supply went bad is also dropped.

Each accepted strobe yields one single-cycle byte-write event with its address and data. A downstream page buffer consumes that event.

Top module: `wr_strobe_qual`

## Requirements
- R1: A write event is produced only for a strobe interval in which `ce_n`=0, `we_n`=0, `oe_n`=1 and `supply_ok`=1 held together.
- R2: The event address is the value on `addr` sampled at the clock that first sees the strobe open. Address changes later in the strobe do not affect it, whichever enable falls last.
- R3: The event data is the value on `din` sampled at the clock that first sees the strobe closed. Data changes after that point do not affect it, whichever enable rises first.
- R4: `wr_valid` is high for exactly one clock per accepted strobe and is never high on two consecutive clocks.
- R5: A strobe seen for fewer than MIN_CLKS consecutive samples produces no event. With the default parameters (2500 ps clock, 10000 ps minimum pulse), MIN_CLKS is 4. The outputs `wr_addr` and `wr_data` keep their previous values when no event is produced.
- R6: When `oe_n` is 0 throughout, or `oe_n` falls while the enables are low, no event is produced.
- R7: When `supply_ok` is 0 throughout, or `supply_ok` falls while the enables are low, no event is produced.
- R8: During and directly after reset, `wr_valid`, `wr_addr` and `wr_data` are all zero.
- R9: With two synchroniser stages, `wr_valid` is high during the clock that follows the third rising clock edge after the pin edge that closes the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable pin, active low, asynchronous |
| we_n | input | 1 | Write enable pin, active low, asynchronous |
| oe_n | input | 1 | Output enable pin, active low, asynchronous |
| supply_ok | input | 1 | High while the supply is above the write threshold |
| addr | input | ADDR_W | Address bus |
| din | input | DATA_W | Data bus |
| wr_valid | output | 1 | Single-cycle byte-write event |
| wr_addr | output | ADDR_W | Address of the last accepted write |
| wr_data | output | DATA_W | Data of the last accepted write |

## Verification
The assertions assume that the address and data buses are stable in the sample where the strobe opens and in the sample where it closes, so that bus and pin samples line up after synchronisation. The stimulus guarantees this by changing pins only on falling clock edges. It sets the final data one clock before the closing edge and changes it no sooner than one clock after. It moves the address only after the opening sample. Pins change on whole clock cycles, so pulse lengths are exact sample counts. The random mix covers lengths both below and above the minimum, with both enable orderings and occasional inhibit or supply-loss cases.

// File: rtl/wsq_pkg.sv
package wsq_pkg;
    // Index of each control pin inside the synchronised pin vector.
    localparam int PIN_CE   = 0;
    localparam int PIN_WE   = 1;
    localparam int PIN_OE   = 2;
    localparam int PIN_PG   = 3;
    localparam int NUM_PINS = 4;

    // Number of whole clock periods needed to cover a span, rounded up.
    function automatic int clks_for(input int span_ps, input int clk_ps);
        return (span_ps + clk_ps - 1) / clk_ps;
    endfunction
endpackage

// File: rtl/wsq_sync.sv
module wsq_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= RST_VAL;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/wsq_gate.sv
module wsq_gate
    import wsq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pins,
    output logic                strobe,
    output logic                start,
    output logic                close,
    output logic                oe_ok,
    output logic                pg_ok
);
    logic prev_q, prev_d;

    // R1: the strobe is the overlap of both enables with output enable
    // inactive and the supply good.
    always_comb begin
        strobe = !pins[PIN_CE] && !pins[PIN_WE] && pins[PIN_OE] && pins[PIN_PG];
        prev_d = strobe;
        start  = strobe && !prev_q;
        close  = !strobe && prev_q;
        oe_ok  = pins[PIN_OE];
        pg_ok  = pins[PIN_PG];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    // R2: a strobe opens once; the following sample cannot open it again.
    p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);
endmodule

// File: rtl/wsq_width.sv
module wsq_width #(
    parameter int MIN_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic long_enough
);
    localparam int CW = $clog2(MIN_CLKS + 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        if (!active)                        cnt_d = '0;
        else if (cnt_q == CW'(MIN_CLKS))    cnt_d = cnt_q;
        else                                cnt_d = cnt_q + 1'b1;
        long_enough = (cnt_q == CW'(MIN_CLKS));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R5: the width count saturates at the threshold.
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(MIN_CLKS));
endmodule

// File: rtl/wsq_capture.sv
module wsq_capture #(
    parameter int AW = 15,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          close,
    input  logic          long_enough,
    input  logic          oe_ok,
    input  logic          pg_ok,
    input  logic [AW-1:0] addr_s,
    input  logic [DW-1:0] data_s,
    output logic          ev_valid,
    output logic [AW-1:0] ev_addr,
    output logic [DW-1:0] ev_data
);
    typedef struct packed {
        logic [AW-1:0] cand;
        logic          valid;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } cap_t;

    cap_t cur_q, nxt_d;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.valid = 1'b0;
        if (start) begin
            nxt_d.cand = addr_s;
        end
        if (close && long_enough && oe_ok && pg_ok) begin
            nxt_d.valid = 1'b1;
            nxt_d.addr  = cur_q.cand;
            nxt_d.data  = data_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign ev_valid = cur_q.valid;
    assign ev_addr  = cur_q.addr;
    assign ev_data  = cur_q.data;

    p_event_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |=> !ev_valid);

    p_short_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (close && !long_enough) |=> !ev_valid);

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_valid |-> ($stable(ev_addr) && $stable(ev_data)));

    p_inhibit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (close && !oe_ok) |=> !ev_valid);

    p_supply_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (close && !pg_ok) |=> !ev_valid);
endmodule

// File: rtl/wr_strobe_qual.sv
module wr_strobe_qual
    import wsq_pkg::*;
#(
    parameter int ADDR_W       = 15,
    parameter int DATA_W       = 8,
    parameter int CLK_PS       = 2500,
    parameter int MIN_PULSE_PS = 10000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              supply_ok,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam int MIN_RAW  = clks_for(MIN_PULSE_PS, CLK_PS);
    localparam int MIN_CLKS = (MIN_RAW < 1) ? 1 : MIN_RAW;
    localparam int BUS_W    = ADDR_W + DATA_W;
    // Idle pin levels: enables inactive, supply assumed bad.
    localparam logic [NUM_PINS-1:0] PIN_IDLE = NUM_PINS'(4'b0111);

    logic [NUM_PINS-1:0] pins_raw, pins_s;
    logic [BUS_W-1:0]    bus_s;
    logic                strobe, start, close, oe_ok, pg_ok, long_enough;

    always_comb begin
        pins_raw         = '0;
        pins_raw[PIN_CE] = ce_n;
        pins_raw[PIN_WE] = we_n;
        pins_raw[PIN_OE] = oe_n;
        pins_raw[PIN_PG] = supply_ok;
    end

    wsq_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .din(pins_raw), .dout(pins_s)
    );

    wsq_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
        .clk(clk), .rst_n(rst_n), .din({addr, din}), .dout(bus_s)
    );

    wsq_gate u_gate (
        .clk(clk), .rst_n(rst_n), .pins(pins_s),
        .strobe(strobe), .start(start), .close(close),
        .oe_ok(oe_ok), .pg_ok(pg_ok)
    );

    wsq_width #(.MIN_CLKS(MIN_CLKS)) u_width (
        .clk(clk), .rst_n(rst_n), .active(strobe), .long_enough(long_enough)
    );

    wsq_capture #(.AW(ADDR_W), .DW(DATA_W)) u_capture (
        .clk(clk), .rst_n(rst_n),
        .start(start), .close(close), .long_enough(long_enough),
        .oe_ok(oe_ok), .pg_ok(pg_ok),
        .addr_s(bus_s[BUS_W-1 -: ADDR_W]), .data_s(bus_s[DATA_W-1:0]),
        .ev_valid(wr_valid), .ev_addr(wr_addr), .ev_data(wr_data)
    );
endmodule

// File: tb/wr_strobe_qual_test.sv
module wr_strobe_qual_test;
    localparam int AW   = 15;
    localparam int DW   = 8;
    localparam int MINC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, supply_ok = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic          wr_valid;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    wr_strobe_qual #(.ADDR_W(AW), .DATA_W(DW), .CLK_PS(2500),
                     .MIN_PULSE_PS(10000), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .supply_ok(supply_ok), .addr(addr), .din(din),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, fails = 0;
    int ev_cnt = 0, ev_cyc = 0, dbl = 0;
    logic [AW-1:0] ev_a = '0, m_addr = '0;
    logic [DW-1:0] ev_d = '0, m_data = '0;
    logic prev_v = 1'b0;

    always @(negedge clk) begin
        if (rst_n && wr_valid) begin
            ev_cnt = ev_cnt + 1;
            ev_a   = wr_addr;
            ev_d   = wr_data;
            ev_cyc = cyc;
            if (prev_v) dbl = dbl + 1;
        end
        prev_v = rst_n && wr_valid;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit exp_fire(input int n, input bit oe_ok, input bit pg_ok);
        return (n >= MINC) && oe_ok && pg_ok;
    endfunction

    task automatic check_held(input string req);
        chk(wr_addr == m_addr, req, "held address", int'(wr_addr), int'(m_addr));
        chk(wr_data == m_data, req, "held data", int'(wr_data), int'(m_data));
    endtask

    // One write attempt; mode 0 moves both enables together, mode 1 lowers
    // write enable first and raises it first.
    task automatic txn(input logic [AW-1:0] a, input logic [DW-1:0] d, input int n,
                       input bit mode, input bit oe_ok, input bit pg_ok, input string req);
        int base, close_cyc;
        bit fire;
        base = ev_cnt;
        fire = exp_fire(n, oe_ok, pg_ok);
        @(negedge clk);
        supply_ok = pg_ok;
        oe_n      = oe_ok;
        if (mode) begin
            we_n = 1'b0;
            addr = AW'($urandom);
            @(negedge clk);
        end
        ce_n = 1'b0;
        we_n = 1'b0;
        addr = a;
        din  = (n > 1) ? ~d : d;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (i < n) begin
                addr = ~a;
                if (i == n - 1) din = d;
            end
        end
        close_cyc = cyc;
        if (mode) begin
            we_n = 1'b1;
        end else begin
            ce_n = 1'b1;
            we_n = 1'b1;
        end
        @(negedge clk);
        din  = ~d;
        ce_n = 1'b1;
        addr = ~a;
        repeat (6) @(negedge clk);
        oe_n      = 1'b1;
        supply_ok = 1'b1;
        chk((ev_cnt - base) == int'(fire), req, "event count", ev_cnt - base, int'(fire));
        if (fire) begin
            chk(ev_a == a, "R2", "event address", int'(ev_a), int'(a));
            chk(ev_d == d, "R3", "event data", int'(ev_d), int'(d));
            chk(ev_cyc == close_cyc + 3, "R9", "event latency", ev_cyc - close_cyc, 3);
            m_addr = a;
            m_data = d;
        end
        check_held(fire ? req : "R5");
    endtask

    // Long strobe cut by output enable (which=0) or supply loss (which=1).
    task automatic abort_txn(input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input bit which, input string req);
        int base;
        base = ev_cnt;
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; addr = a; din = d;
        repeat (6) @(negedge clk);
        if (which) supply_ok = 1'b0;
        else       oe_n = 1'b0;
        repeat (2) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        repeat (2) @(negedge clk);
        oe_n = 1'b1; supply_ok = 1'b1;
        repeat (5) @(negedge clk);
        chk(ev_cnt == base, req, "event after abort", ev_cnt - base, 0);
        check_held(req);
    endtask

    bit done = 1'b0;

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        chk(wr_valid == 1'b0, "R8", "valid in reset", int'(wr_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wr_valid == 1'b0, "R8", "valid after reset", int'(wr_valid), 0);
        chk(wr_addr == '0, "R8", "address after reset", int'(wr_addr), 0);
        chk(wr_data == '0, "R8", "data after reset", int'(wr_data), 0);
        repeat (3) @(negedge clk);

        txn(15'h5555, 8'hAA, 8, 1'b0, 1'b1, 1'b1, "R1");
        txn(15'h2AAA, 8'h55, 6, 1'b1, 1'b1, 1'b1, "R2");
        txn(15'h1234, 8'hC3, 5, 1'b1, 1'b1, 1'b1, "R3");
        txn(15'h0F0F, 8'h11, 3, 1'b0, 1'b1, 1'b1, "R5");
        txn(15'h0F0F, 8'h22, 1, 1'b1, 1'b1, 1'b1, "R5");
        txn(15'h7001, 8'h99, MINC, 1'b0, 1'b1, 1'b1, "R5");
        txn(15'h3333, 8'h44, 8, 1'b0, 1'b0, 1'b1, "R6");
        abort_txn(15'h6666, 8'h77, 1'b0, "R6");
        txn(15'h4444, 8'h88, 8, 1'b1, 1'b1, 1'b0, "R7");
        abort_txn(15'h1111, 8'hEE, 1'b1, "R7");
        txn(15'h7FFF, 8'hFF, 7, 1'b1, 1'b1, 1'b1, "R4");

        for (int k = 0; k < 60; k++) begin
            logic [AW-1:0] ra;
            logic [DW-1:0] rd;
            int rn;
            bit rm, ro, rp;
            ra = AW'($urandom);
            rd = DW'($urandom);
            rn = 1 + int'($urandom % 8);
            rm = 1'($urandom % 2);
            ro = ($urandom % 8) != 0;
            rp = ($urandom % 8) != 0;
            txn(ra, rd, rn, rm, ro, rp, "R1");
        end

        chk(dbl == 0, "R4", "back-to-back valid cycles", dbl, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R4 watchdog: actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule